// File: doc/BRIEF.md
# Pixel Format Converter and Serializer

This block sits between a framebuffer reader and a display timing generator. Each input transfer carries one pixel word. The block turns that word into a 24-bit colour value with 8 bits each of red, green and blue. It then sends the value downstream as three 8-bit beats: red first, then green, then blue.

Two input encodings are chosen at elaboration time:

- **32-bit mode.** The word holds a spare top byte followed by 8-bit red, green and blue. The spare byte is dropped.
- **16-bit 5:6:5 mode.** The word is widened to 8:8:8. The added low bits are either zeros or copies of each channel's own top bits, chosen by a second parameter.

Both sides use valid/ready handshaking. Start-of-packet and end-of-packet markers travel with the pixel onto its first and last beat.

A single holding register keeps the current pixel while its beats go out. The block accepts the next pixel on the same cycle that the blue beat leaves, so an unstalled stream moves one pixel every three cycles.

Top module: `pixel_serializer`

## Requirements
- R1: In 32-bit mode, red is in_data_i[23:16], green is in_data_i[15:8] and blue is in_data_i[7:0]. Bits 31:24 have no effect on any output beat.
- R2: In 16-bit mode, red is in_data_i[15:11], green is in_data_i[10:5] and blue is in_data_i[4:0]. Bits 31:16 have no effect on any output beat.
- R3: With zero padding, each widened channel carries the source bits in its top positions and zeros below them (red and blue get 3 zero bits, green gets 2).
- R4: With replicate padding, each widened channel is the source bits followed by that channel's own most significant bits: red {r[4:0], r[4:2]}, green {g[5:0], g[5:4]}, blue {b[4:0], b[4:2]}.
- R5: Every accepted pixel produces exactly three output beats, in the order red, green, blue.
- R6: in_ready_o is high exactly when no beat of an earlier pixel is outstanding, or when the last outstanding beat is the blue beat and it is being transferred in this cycle. No pixel is taken while in_ready_o is low.
- R7: out_sop_o is high only on the red beat of a pixel that arrived with in_sop_i set. out_eop_o is high only on the blue beat of a pixel that arrived with in_eop_i set.
- R8: A beat advances only on a cycle where out_valid_o and out_ready_i are both high. While out_valid_o is high and out_ready_i is low, out_data_o, out_sop_o and out_eop_o hold their values.
- R9: Asynchronous active-low reset clears the beat position and output valid. After reset, out_valid_o is low, in_ready_o is high, and the first beat sent is red.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_data_i | input | 32 | Pixel word from the framebuffer side |
| in_sop_i | input | 1 | Pixel opens a packet |
| in_eop_i | input | 1 | Pixel closes a packet |
| in_valid_i | input | 1 | Input pixel present |
| in_ready_o | output | 1 | Block can take a pixel this cycle |
| out_data_o | output | 8 | Current colour beat |
| out_sop_o | output | 1 | Start-of-packet marker on the red beat |
| out_eop_o | output | 1 | End-of-packet marker on the blue beat |
| out_valid_o | output | 1 | Output beat present |
| out_ready_i | input | 1 | Downstream accepts the beat |

## Verification
Three instances run side by side on one stream: 32-bit, 16-bit with zero padding, and 16-bit with replicate padding.

**Expansion corners.** Directed words exercise all-ones, all-zero and single-channel values. A wrong pad mode shows up here: for example, 0xF8 appears where 0xFF is expected. Random junk in the ignored high bits exposes a slice taken from the wrong position.

**Handshake corners.** Random backpressure lands on every beat position. This exposes three classes of fault:
- A design that drops or repeats a beat under a stall, or changes the beat while stalled.
- A design that does not accept the next pixel on the blue-beat transfer cycle, seen as a wrong in_ready_o.
- A design that takes a pixel too early and overwrites pending beats.

**Packet markers.** SOP and EOP values are randomized per pixel. A marker placed on the wrong beat causes a mismatch.

// File: rtl/pxs_pkg.sv
package pxs_pkg;
  localparam int unsigned CH_W  = 8;
  localparam int unsigned IN_W  = 32;
  localparam int unsigned BEATS = 3;

  typedef enum logic {FMT_XRGB8888 = 1'b0, FMT_RGB565 = 1'b1} pxs_fmt_e;
  typedef enum logic {PAD_ZERO = 1'b0, PAD_REPL = 1'b1} pxs_pad_e;
endpackage

// File: rtl/pxs_widen.sv
// Widen one colour channel to DST_W bits.
module pxs_widen
  import pxs_pkg::*;
#(
  parameter int unsigned SRC_W = 5,
  parameter int unsigned DST_W = 8,
  parameter pxs_pad_e    PAD   = PAD_ZERO
) (
  input  logic [SRC_W-1:0] src_i,
  output logic [DST_W-1:0] dst_o
);
  localparam int unsigned ADD_W = DST_W - SRC_W;

  generate
    if (ADD_W == 0) begin : g_pass
      assign dst_o = src_i;
    end else if (PAD == PAD_REPL) begin : g_repl
      assign dst_o = {src_i, src_i[SRC_W-1 -: ADD_W]};
    end else begin : g_zero
      assign dst_o = {src_i, {ADD_W{1'b0}}};
    end
  endgenerate

  initial begin
    assert (DST_W >= SRC_W && ADD_W <= SRC_W)
      else $error("pxs_widen: unsupported width pair");
  end
endmodule

// File: rtl/pxs_unpack.sv
// Split a framebuffer word into three CH_W-bit beats, beat 0 = red.
module pxs_unpack
  import pxs_pkg::*;
#(
  parameter pxs_fmt_e FMT = FMT_XRGB8888,
  parameter pxs_pad_e PAD = PAD_ZERO
) (
  input  logic [IN_W-1:0]             data_i,
  output logic [BEATS-1:0][CH_W-1:0]  beats_o
);
  localparam int unsigned R_W = (FMT == FMT_RGB565) ? 5 : 8;
  localparam int unsigned G_W = (FMT == FMT_RGB565) ? 6 : 8;
  localparam int unsigned B_W = (FMT == FMT_RGB565) ? 5 : 8;
  localparam int unsigned B_LO = 0;
  localparam int unsigned G_LO = B_W;
  localparam int unsigned R_LO = B_W + G_W;
  localparam int unsigned USED_W = R_W + G_W + B_W;

  logic [R_W-1:0] r_raw;
  logic [G_W-1:0] g_raw;
  logic [B_W-1:0] b_raw;
  logic           unused_hi;

  assign r_raw     = data_i[R_LO +: R_W];
  assign g_raw     = data_i[G_LO +: G_W];
  assign b_raw     = data_i[B_LO +: B_W];
  assign unused_hi = ^data_i[IN_W-1:USED_W];

  pxs_widen #(.SRC_W(R_W), .DST_W(CH_W), .PAD(PAD)) u_r (.src_i(r_raw), .dst_o(beats_o[0]));
  pxs_widen #(.SRC_W(G_W), .DST_W(CH_W), .PAD(PAD)) u_g (.src_i(g_raw), .dst_o(beats_o[1]));
  pxs_widen #(.SRC_W(B_W), .DST_W(CH_W), .PAD(PAD)) u_b (.src_i(b_raw), .dst_o(beats_o[2]));
endmodule

// File: rtl/pxs_beat_ser.sv
// Hold one pixel, emit its beats in index order.
module pxs_beat_ser
  import pxs_pkg::*;
#(
  parameter int unsigned N_BEATS = BEATS,
  parameter int unsigned BEAT_W  = CH_W
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [N_BEATS-1:0][BEAT_W-1:0]   beats_i,
  input  logic                             sop_i,
  input  logic                             eop_i,
  input  logic                             valid_i,
  output logic                             ready_o,
  output logic [BEAT_W-1:0]                data_o,
  output logic                             sop_o,
  output logic                             eop_o,
  output logic                             valid_o,
  input  logic                             ready_i
);
  localparam int unsigned CNT_W = $clog2(N_BEATS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(N_BEATS - 1);

  logic [N_BEATS-1:0][BEAT_W-1:0] beats_q;
  logic [CNT_W-1:0]               cnt_q;
  logic                           valid_q, sop_q, eop_q;
  logic                           last, fire_out, take;

  assign last     = (cnt_q == LAST);
  assign fire_out = valid_q && ready_i;
  assign ready_o  = !valid_q || (last && ready_i);
  assign take     = valid_i && ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beats_q <= '0;
      cnt_q   <= '0;
      valid_q <= 1'b0;
      sop_q   <= 1'b0;
      eop_q   <= 1'b0;
    end else if (take) begin
      beats_q <= beats_i;
      sop_q   <= sop_i;
      eop_q   <= eop_i;
      cnt_q   <= '0;
      valid_q <= 1'b1;
    end else if (fire_out) begin
      if (last) begin
        cnt_q   <= '0;
        valid_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign data_o  = beats_q[cnt_q];
  assign valid_o = valid_q;
  assign sop_o   = valid_q && sop_q && (cnt_q == '0);
  assign eop_o   = valid_q && eop_q && last;

  p_hold_stall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(data_o) && $stable(sop_o) && $stable(eop_o));

  p_beat_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_out && !last |=> valid_o && (cnt_q == $past(cnt_q) + 1'b1));

  p_no_overrun_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && ready_o && valid_q |-> ready_i && last);

  p_first_red_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> (cnt_q == '0));

  p_flag_split_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sop_o, eop_o}));
endmodule

// File: rtl/pixel_serializer.sv
module pixel_serializer
  import pxs_pkg::*;
#(
  parameter pxs_fmt_e FMT = FMT_XRGB8888,
  parameter pxs_pad_e PAD = PAD_ZERO
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [IN_W-1:0] in_data_i,
  input  logic            in_sop_i,
  input  logic            in_eop_i,
  input  logic            in_valid_i,
  output logic            in_ready_o,
  output logic [CH_W-1:0] out_data_o,
  output logic            out_sop_o,
  output logic            out_eop_o,
  output logic            out_valid_o,
  input  logic            out_ready_i
);
  logic [BEATS-1:0][CH_W-1:0] beats;

  pxs_unpack #(.FMT(FMT), .PAD(PAD)) u_unpack (
    .data_i  (in_data_i),
    .beats_o (beats)
  );

  pxs_beat_ser #(.N_BEATS(BEATS), .BEAT_W(CH_W)) u_ser (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .beats_i (beats),
    .sop_i   (in_sop_i),
    .eop_i   (in_eop_i),
    .valid_i (in_valid_i),
    .ready_o (in_ready_o),
    .data_o  (out_data_o),
    .sop_o   (out_sop_o),
    .eop_o   (out_eop_o),
    .valid_o (out_valid_o),
    .ready_i (out_ready_i)
  );

  p_ready_when_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> in_ready_o);
endmodule

// File: tb/tb_pixel_serializer.sv
module tb_pixel_serializer;
  import pxs_pkg::*;

  localparam int CLK_P    = 10;
  localparam int N_CYCLES = 4000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_sop = 1'b0, in_eop = 1'b0, in_valid = 1'b0, out_ready = 1'b0;

  logic       rdy_a, rdy_z, rdy_r;
  logic [7:0] dat_a, dat_z, dat_r;
  logic       sop_a, sop_z, sop_r, eop_a, eop_z, eop_r, val_a, val_z, val_r;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  pixel_serializer dut (
    .clk_i(clk), .rst_ni(rst_ni), .in_data_i(in_data), .in_sop_i(in_sop), .in_eop_i(in_eop),
    .in_valid_i(in_valid), .in_ready_o(rdy_a), .out_data_o(dat_a), .out_sop_o(sop_a),
    .out_eop_o(eop_a), .out_valid_o(val_a), .out_ready_i(out_ready));

  pixel_serializer #(.FMT(FMT_RGB565), .PAD(PAD_ZERO)) dut_z (
    .clk_i(clk), .rst_ni(rst_ni), .in_data_i(in_data), .in_sop_i(in_sop), .in_eop_i(in_eop),
    .in_valid_i(in_valid), .in_ready_o(rdy_z), .out_data_o(dat_z), .out_sop_o(sop_z),
    .out_eop_o(eop_z), .out_valid_o(val_z), .out_ready_i(out_ready));

  pixel_serializer #(.FMT(FMT_RGB565), .PAD(PAD_REPL)) dut_r (
    .clk_i(clk), .rst_ni(rst_ni), .in_data_i(in_data), .in_sop_i(in_sop), .in_eop_i(in_eop),
    .in_valid_i(in_valid), .in_ready_o(rdy_r), .out_data_o(dat_r), .out_sop_o(sop_r),
    .out_eop_o(eop_r), .out_valid_o(val_r), .out_ready_i(out_ready));

  typedef struct packed {
    logic [31:0] word;
    logic        sop;
    logic        eop;
  } pix_t;

  pix_t pend[$];
  int   beat_idx = 0;

  // Expected channel: 0 = 32-bit, 1 = 565 zero pad, 2 = 565 replicate pad.
  function automatic logic [7:0] exp_beat(int mode, logic [31:0] w, int b);
    logic [4:0] r5, b5;
    logic [5:0] g6;
    r5 = w[15:11]; g6 = w[10:5]; b5 = w[4:0];
    if (mode == 0) return (b == 0) ? w[23:16] : (b == 1) ? w[15:8] : w[7:0];
    if (mode == 1) return (b == 0) ? {r5, 3'b000} : (b == 1) ? {g6, 2'b00} : {b5, 3'b000};
    return (b == 0) ? {r5, r5[4:2]} : (b == 1) ? {g6, g6[5:4]} : {b5, b5[4:2]};
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string req_of(int mode);
    return (mode == 0) ? "R1" : (mode == 1) ? "R2/R3" : "R2/R4";
  endfunction

  logic [7:0] prev_dat[3];
  logic       prev_sop, prev_eop, prev_stall;

  task automatic compare_beat(int mode, logic [7:0] d, logic s, logic e);
    pix_t p;
    p = pend[0];
    check(d == exp_beat(mode, p.word, beat_idx), req_of(mode), {24'd0, d},
          {24'd0, exp_beat(mode, p.word, beat_idx)});
    check(s == (p.sop && beat_idx == 0), "R7 sop", {31'd0, s}, {31'd0, p.sop && beat_idx == 0});
    check(e == (p.eop && beat_idx == 2), "R7 eop", {31'd0, e}, {31'd0, p.eop && beat_idx == 2});
  endtask

  initial begin
    logic [31:0] directed[6];
    int          n_dir;
    bit          have_pix;
    int          pending;
    bit          exp_rdy;

    directed[0] = 32'h0000_FFFF; directed[1] = 32'h0000_0000; directed[2] = 32'hFFFF_F800;
    directed[3] = 32'hAB00_07E0; directed[4] = 32'h5A12_001F; directed[5] = 32'hFF80_8410;
    n_dir = 0; have_pix = 1'b0; prev_stall = 1'b0;
    void'($urandom(32'd20240517));

    repeat (3) @(posedge clk);
    #1;
    // R9: reset state
    check(!val_a && !val_z && !val_r, "R9 valid", {31'd0, val_a}, 32'd0);
    check(rdy_a && rdy_z && rdy_r, "R9 ready", {31'd0, rdy_a}, 32'd1);
    @(negedge clk);
    rst_ni = 1'b1;

    for (int cyc = 0; cyc < N_CYCLES; cyc++) begin
      @(negedge clk);
      if (!have_pix && (($urandom % 4) != 0)) begin
        have_pix = 1'b1;
        in_data  = (n_dir < 6) ? directed[n_dir] : $urandom;
        n_dir++;
        in_sop   = $urandom % 2;
        in_eop   = $urandom % 2;
      end
      in_valid = have_pix;
      out_ready = (cyc < 40) ? 1'b1 : (($urandom % 3) != 0);
      #1;

      pending = pend.size() * 3 - beat_idx;
      exp_rdy = (pending == 0) || (pending == 1 && out_ready);
      check(rdy_a == exp_rdy && rdy_z == exp_rdy && rdy_r == exp_rdy, "R6",
            {29'd0, rdy_a, rdy_z, rdy_r}, {31'd0, exp_rdy});
      check(val_a == (pending > 0) && val_z == (pending > 0) && val_r == (pending > 0), "R5 valid",
            {29'd0, val_a, val_z, val_r}, {31'd0, pending > 0});

      if (prev_stall && val_a) begin
        check(dat_a == prev_dat[0] && dat_z == prev_dat[1] && dat_r == prev_dat[2]
              && sop_a == prev_sop && eop_a == prev_eop, "R8 hold",
              {8'd0, dat_a, dat_z, dat_r}, {8'd0, prev_dat[0], prev_dat[1], prev_dat[2]});
      end

      if (pending > 0) begin
        compare_beat(0, dat_a, sop_a, eop_a);
        compare_beat(1, dat_z, sop_z, eop_z);
        compare_beat(2, dat_r, sop_r, eop_r);
      end

      prev_stall = val_a && !out_ready;
      prev_dat[0] = dat_a; prev_dat[1] = dat_z; prev_dat[2] = dat_r;
      prev_sop = sop_a; prev_eop = eop_a;

      // Model update for the coming edge (R5 order, R6 acceptance).
      if (pending > 0 && out_ready) begin
        beat_idx++;
        if (beat_idx == 3) begin
          beat_idx = 0;
          void'(pend.pop_front());
        end
      end
      if (in_valid && exp_rdy) begin
        pix_t p;
        p.word = in_data; p.sop = in_sop; p.eop = in_eop;
        pend.push_back(p);
        have_pix = 1'b0;
      end
    end
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        #(CLK_P * 200000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule